// File: doc/BRIEF.md
# Three-Register Accumulator Processor Core

This block is a 16-bit Harvard-style processor core. Instructions arrive on a 16-bit input from an external instruction store that is addressed by the program counter output. Data travels over a separate read bus, write bus, address output and write strobe. The core holds three registers. A is both an operand and the data address. D is the main accumulator. W is a third register that the two spare high bits of the compute format can select and write.

Each instruction takes one clock cycle. An instruction with a clear top bit loads a 15-bit constant into A. An instruction with a set top bit is a compute instruction. Its ALU combines D with an operand chosen from A, the data read bus or W. The result can go to any mix of A, D, memory and W, and the PC can branch to A according to the sign of the result. Old programs, which always set bits 14 and 13, run unchanged and never touch W.

A small single-port data RAM comes with the core for system-level testing. It is clocked on the falling edge of the core clock. Because of this, a read that follows a constant load gets its data within the same cycle.

Top module: `wacc_cpu`

## Requirements
- R1: With instruction bit 15 = 0, A loads {0, bits 14..0} on the next rising edge and shows on `mem_addr_o` from then on. Such an instruction never raises `mem_we_o`, even when bit 3 is set.
- R2: In a compute instruction, the selector {~bit 14, bit 12} picks the ALU operand: 00 picks A, 01 picks `mem_rdata_i`, 10 picks W. Code 11 may return any value.
- R3: In a compute instruction, bit 13 = 0 loads the ALU result into W on the next rising edge. Bit 13 = 1 leaves W unchanged.
- R4: A compute instruction with bits 14 and 13 both 1 picks A (bit 12 = 0) or memory (bit 12 = 1) and leaves W unchanged.
- R5: Bits 11..6 act in this order: zero D, invert D, zero operand, invert operand, then add (1) or AND (0), then invert the result. The result drives `mem_wdata_o` during a compute instruction.
- R6: In a compute instruction, bits 5, 4 and 3 write A, D and memory. `mem_we_o` equals bit 3 in the same cycle.
- R7: Bits 2, 1 and 0 enable the tests result < 0, result = 0 and result > 0. If an enabled test holds, the PC loads A[14:0] on the next rising edge. Otherwise the PC advances by one.
- R8: A low `rst_n` clears the PC at once and blocks all writes. After `rst_n` rises, the PC first advances on the third rising edge.
- R9: The data RAM reads and writes on the falling clock edge. Its read data for the address A took at the last rising edge is valid before the next rising edge. On a write it returns the old word, and the new word is readable from the next falling edge.
- R10: The all-zero instruction acts as a no-op. It sets A to 0 and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| instr_i | input | 16 | Instruction word at the current PC |
| mem_rdata_i | input | 16 | Data word read at `mem_addr_o` |
| mem_wdata_o | output | 16 | ALU result, the data to write |
| mem_addr_o | output | 15 | Data address, the low bits of A |
| mem_we_o | output | 1 | Data write strobe |
| pc_o | output | 15 | Program counter, the instruction address |

## Verification
The ALU result and the write strobe are combinational, so they are due in the same cycle as the instruction that causes them. A new value of A, D, W or the PC is only visible after the following rising edge, and a memory read needs the falling edge in between. The bench therefore presents each instruction 1 ns after a rising edge and samples 3 ns before the next one. Each vector's expected address and PC describe the state before that instruction, so every register effect is checked one vector later. The reset checks count rising edges after `rst_n` rises, to confirm that the PC stays at 0 for two edges and steps on the third.

// File: rtl/wacc_pkg.sv
package wacc_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 15;

  // operand picked for the ALU's second input
  typedef enum logic [1:0] {
    OPD_A   = 2'b00,
    OPD_MEM = 2'b01,
    OPD_W   = 2'b10,
    OPD_RSV = 2'b11
  } opd_sel_e;

  // MSB first: matches instruction bits 11..6
  typedef struct packed {
    logic zero_d;
    logic inv_d;
    logic zero_s;
    logic inv_s;
    logic add;
    logic inv_out;
  } alu_ctl_t;

  typedef struct packed {
    logic      is_comp;
    logic      ld_const;
    opd_sel_e  opd_sel;
    alu_ctl_t  alu;
    logic      wr_a;
    logic      wr_d;
    logic      wr_m;
    logic      wr_w;
    logic [2:0] jmask;
  } dec_t;

endpackage

// File: rtl/wacc_decode.sv
module wacc_decode
  import wacc_pkg::*;
#(
  parameter int unsigned IW = WORD_W
) (
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);

  localparam int unsigned B_KIND = IW - 1;
  localparam int unsigned B_WSEL = IW - 2;
  localparam int unsigned B_WWRN = IW - 3;
  localparam int unsigned B_MSEL = IW - 4;

  always_comb begin
    dec_o          = '0;
    dec_o.is_comp  = instr_i[B_KIND];
    dec_o.ld_const = ~instr_i[B_KIND];
    dec_o.opd_sel  = opd_sel_e'({~instr_i[B_WSEL], instr_i[B_MSEL]});
    dec_o.alu      = alu_ctl_t'(instr_i[11:6]);
    if (instr_i[B_KIND]) begin
      dec_o.wr_a  = instr_i[5];
      dec_o.wr_d  = instr_i[4];
      dec_o.wr_m  = instr_i[3];
      dec_o.wr_w  = ~instr_i[B_WWRN];
      dec_o.jmask = instr_i[2:0];
    end
  end

endmodule

// File: rtl/wacc_alu.sv
module wacc_alu
  import wacc_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] s_i,
  input  alu_ctl_t      ctl_i,
  output logic [DW-1:0] res_o,
  output logic          zr_o,
  output logic          ng_o
);

  logic [DW-1:0] d_x, s_x, raw;

  always_comb begin
    d_x = ctl_i.zero_d ? '0 : d_i;
    if (ctl_i.inv_d) d_x = ~d_x;
    s_x = ctl_i.zero_s ? '0 : s_i;
    if (ctl_i.inv_s) s_x = ~s_x;
    raw   = ctl_i.add ? (d_x + s_x) : (d_x & s_x);
    res_o = ctl_i.inv_out ? ~raw : raw;
  end

  assign zr_o = (res_o == '0);
  assign ng_o = res_o[DW-1];

endmodule

// File: rtl/wacc_pc.sv
module wacc_pc #(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          is_comp_i,
  input  logic [2:0]    jmask_i,
  input  logic          zr_i,
  input  logic          ng_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o
);

  localparam logic [AW-1:0] STEP = AW'(1);

  logic          take;
  logic [AW-1:0] pc_d, pc_q;

  always_comb begin
    take = is_comp_i & ((jmask_i[2] & ng_i) |
                        (jmask_i[1] & zr_i) |
                        (jmask_i[0] & ~ng_i & ~zr_i));
    pc_d = take ? tgt_i : (pc_q + STEP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R8: while reset is held the counter sits at zero
  a_r8_pc_cleared: assert property (@(posedge clk_i) !rst_ni |-> pc_q == '0);

  // R7: fall-through advances by one
  a_r7_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && !take) |=> pc_q == $past(pc_q) + STEP);

  // R7: a taken branch lands on the target
  a_r7_pc_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && take) |=> pc_q == $past(tgt_i));

endmodule

// File: rtl/wacc_dram.sv
module wacc_dram #(
  parameter int unsigned DW  = 16,
  parameter int unsigned LAW = 8
) (
  input  logic           clk_i,
  input  logic [LAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  output logic [DW-1:0]  rdata_o
);

  localparam int unsigned DEPTH = 1 << LAW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  // inverted core clock: both ports act on the falling edge, read-first
  always_ff @(negedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rd_q <= mem_q[addr_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/wacc_cpu.sv
module wacc_cpu
  import wacc_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] instr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [AW-1:0] pc_o
);

  localparam int unsigned B_WWRN = DW - 3;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  dec_t          dec;
  logic [DW-1:0] a_q, d_q, w_q;
  logic [DW-1:0] a_d;
  logic          a_en, d_en, w_en;
  logic [DW-1:0] opd_s, alu_res;
  logic          alu_zr, alu_ng;

  wacc_decode #(.IW(DW)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  always_comb begin
    case (dec.opd_sel)
      OPD_A:   opd_s = a_q;
      OPD_MEM: opd_s = mem_rdata_i;
      default: opd_s = w_q;
    endcase
  end

  wacc_alu #(.DW(DW)) u_alu (
    .d_i   (d_q),
    .s_i   (opd_s),
    .ctl_i (dec.alu),
    .res_o (alu_res),
    .zr_o  (alu_zr),
    .ng_o  (alu_ng)
  );

  // next state and enables
  always_comb begin
    a_en = core_rst_n & (dec.ld_const | dec.wr_a);
    d_en = core_rst_n & dec.wr_d;
    w_en = core_rst_n & dec.wr_w;
    a_d  = dec.ld_const ? {1'b0, instr_i[DW-2:0]} : alu_res;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= a_d;
  end

  always_ff @(posedge clk) begin
    if (d_en) d_q <= alu_res;
  end

  always_ff @(posedge clk) begin
    if (w_en) w_q <= alu_res;
  end

  wacc_pc #(.AW(AW)) u_pc (
    .clk_i     (clk),
    .rst_ni    (core_rst_n),
    .is_comp_i (dec.is_comp),
    .jmask_i   (dec.jmask),
    .zr_i      (alu_zr),
    .ng_i      (alu_ng),
    .tgt_i     (a_q[AW-1:0]),
    .pc_o      (pc_o)
  );

  assign mem_addr_o  = a_q[AW-1:0];
  assign mem_wdata_o = alu_res;
  assign mem_we_o    = core_rst_n & dec.wr_m;

  // R1: a constant load appears on the address bus one edge later
  a_r1_const_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && !instr_i[DW-1]) |=> mem_addr_o == $past(instr_i[AW-1:0]));

  // R6: the strobe only follows bit 3 of a compute word
  a_r6_we_compute_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (instr_i[DW-1] && instr_i[3]));

  // R3: an active-low W write captures the ALU result
  a_r3_w_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && instr_i[DW-1] && !instr_i[B_WWRN]) |=> w_q == $past(alu_res));

  // R3 and R4: without that request W keeps its value
  a_r4_w_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && !(instr_i[DW-1] && !instr_i[B_WWRN])) |=> $stable(w_q));

endmodule

// File: tb/wacc_cpu_tb_top.sv
module wacc_cpu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int AW  = 15;
  localparam int LAW = 8;
  localparam int NV  = 31;

  // {instr, pc before, addr before, alu result, we, check addr, check result, req}
  localparam logic [68:0] VEC [0:NV-1] = '{
    {16'h0005, 15'd0,  15'd0,   16'h0000, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 @5
    {16'hEC10, 15'd1,  15'd5,   16'h0005, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 D=A
    {16'h0064, 15'd2,  15'd5,   16'h0000, 1'b0, 1'b1, 1'b0, 4'd1},  // R1 @100
    {16'hE308, 15'd3,  15'd100, 16'h0005, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 M=D
    {16'h0000, 15'd4,  15'd100, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 no-op
    {16'h0064, 15'd5,  15'd0,   16'h0000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 A now 0
    {16'hFDD0, 15'd6,  15'd100, 16'h0006, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 D=M+1
    {16'hC300, 15'd7,  15'd100, 16'h0006, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 W=D
    {16'hADD0, 15'd8,  15'd100, 16'h0007, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 D=W+1
    {16'hE090, 15'd9,  15'd100, 16'h006B, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 D=D+A
    {16'hAC10, 15'd10, 15'd100, 16'h0006, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 W kept
    {16'h8C80, 15'd11, 15'd100, 16'h0005, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 W=W-1
    {16'h0014, 15'd12, 15'd100, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd1},  // R1 @20
    {16'hE384, 15'd13, 15'd20,  16'h0005, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 JLT not taken
    {16'hE301, 15'd14, 15'd20,  16'h0006, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 JGT taken
    {16'hEA82, 15'd20, 15'd20,  16'h0000, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 JEQ taken
    {16'hEE82, 15'd20, 15'd20,  16'hFFFF, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 JEQ not taken
    {16'hEE85, 15'd21, 15'd20,  16'hFFFF, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 JNE taken
    {16'hAC30, 15'd20, 15'd20,  16'h0005, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 AD=W
    {16'hC088, 15'd21, 15'd5,   16'h000A, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 MW=D+A
    {16'hAC10, 15'd22, 15'd5,   16'h000A, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 W loaded
    {16'h0000, 15'd23, 15'd5,   16'h0000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10
    {16'h0005, 15'd24, 15'd0,   16'h0000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10
    {16'hFC10, 15'd25, 15'd5,   16'h000A, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 D=M
    {16'hE000, 15'd26, 15'd5,   16'h0000, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 D&A
    {16'hE540, 15'd27, 15'd5,   16'h000F, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 D|A
    {16'hE340, 15'd28, 15'd5,   16'hFFF5, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 !D
    {16'hE4C0, 15'd29, 15'd5,   16'h0005, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 D-A
    {16'hECC0, 15'd30, 15'd5,   16'hFFFB, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 -A
    {16'h0008, 15'd31, 15'd5,   16'h0000, 1'b0, 1'b1, 1'b0, 4'd1},  // R1 bit 3 set, no strobe
    {16'h0000, 15'd32, 15'd8,   16'h0000, 1'b0, 1'b1, 1'b0, 4'd1}   // R1 A=8
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] instr;
  logic [DW-1:0] rdata, wdata;
  logic [AW-1:0] addr, pc;
  logic          we;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wacc_cpu #(.DW(DW), .AW(AW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr),
    .mem_rdata_i (rdata),
    .mem_wdata_o (wdata),
    .mem_addr_o  (addr),
    .mem_we_o    (we),
    .pc_o        (pc)
  );

  wacc_dram #(.DW(DW), .LAW(LAW)) ram_i (
    .clk_i   (clk),
    .addr_i  (addr[LAW-1:0]),
    .wdata_i (wdata),
    .we_i    (we),
    .rdata_o (rdata)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 4000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    instr = '0;
    #3;
    check("R8 pc in reset", 32'(pc), 32'd0);
    check("R8 strobe in reset", 32'(we), 32'd0);
    @(posedge clk);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      instr = VEC[i][68:53];
      #(CLK_PERIOD - 3);
      check($sformatf("R%0d step %0d pc", VEC[i][3:0], i), 32'(pc), 32'(VEC[i][52:38]));
      check($sformatf("R%0d step %0d strobe", VEC[i][3:0], i), 32'(we), 32'(VEC[i][6]));
      if (VEC[i][5])
        check($sformatf("R%0d step %0d addr", VEC[i][3:0], i), 32'(addr), 32'(VEC[i][37:23]));
      if (VEC[i][4])
        check($sformatf("R%0d step %0d result", VEC[i][3:0], i), 32'(wdata), 32'(VEC[i][22:7]));
      @(posedge clk);
      #1;
    end

    // R6: strobe follows a compute write request, then reset kills it (R8)
    instr = 16'hE308;
    #2;
    check("R6 strobe on M=D", 32'(we), 32'd1);
    rst_n = 1'b0;
    #1;
    check("R8 async pc clear", 32'(pc), 32'd0);
    check("R8 strobe blocked", 32'(we), 32'd0);
    @(posedge clk);
    @(posedge clk);
    #1;
    instr = '0;
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2;
    check("R8 pc held two edges", 32'(pc), 32'd0);
    @(posedge clk);
    #2;
    check("R8 pc steps on third edge", 32'(pc), 32'd1);
    @(posedge clk);
    #2;
    check("R7 pc keeps counting", 32'(pc), 32'd2);

    summary();
    $finish;
  end

endmodule